// File: doc/BRIEF.md
# Scatter-Accumulate Write Engine

This block performs a vector scatter with add-accumulate into a local byte memory. Accumulation happens in two phases. In the first phase, the log phase, the client presents one element per cycle. Each element carries a base address, an increment value, a region length, an element index and an optional predicate vector. The engine splits the element into bytes and records each byte in a byte-wide log slot: the byte's address, its increment byte and a valid bit. A byte is valid only when it lies inside the inclusive region and its predicate bit allows it.

In the second phase, the commit phase, the engine walks the log in steps of the commit element size. For every element whose first byte is valid, it reads the current memory contents, adds the logged increment, writes the sum back, and clears the log slots it consumed. The memory is a single-port synchronous byte array with one cycle of read latency. The engine reports that a commit is in progress with `busy` and marks the end with a one-cycle `done` pulse.

Top module: `scat_acc_engine`

## Requirements
- R1: After reset, `busy`, `done`, `mem_rd` and `mem_wr` are all low.
- R2: A logged element of size S (S=4 when `log_word`=1, S=2 otherwise) at index `log_idx` fills slots S*idx+off for off in 0..S-1. Each such slot holds address (`log_addr`+off) mod 256 and byte off of `log_inc`, where byte 0 is bits 7:0 (little-endian).
- R3: A slot is valid only if its address is at or below (`log_addr`+`log_len`) mod 256, with the bound inclusive. With `log_addr`=0xFE and `log_len`=3 the bound wraps to 0x01, so byte 0 is invalid.
- R4: When `log_pred_en`=1, slot k is valid only if `log_pred[k]`=1. When `log_pred_en`=0, the predicate is ignored.
- R5: A commit of size S (S=4 when `commit_word`=1) visits slots 0, S, 2S, and so on. It processes an element only if the valid bit of its first slot is set. Memory covered by skipped elements stays unchanged.
- R6: For a processed element, the S memory bytes at the logged addresses and the S logged bytes are each assembled little-endian and added modulo 2^(8S). The sum is written back byte by byte to the same logged addresses, even for bytes whose own valid bit is clear.
- R7: Each processed slot has its valid bit and data byte cleared, so a second commit with no new log leaves memory unchanged.
- R8: `busy` rises in the cycle after an accepted commit request and stays high until `done`. `done` is high for exactly one cycle, and `busy` is low in the cycle after it.
- R9: While `busy` is high, `log_valid` and `commit_req` are ignored.
- R10: A log entry and a commit request presented in the same idle cycle are both accepted, and the commit includes that entry.
- R11: `mem_rd` and `mem_wr` are never high together, and neither is high while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| log_valid | input | 1 | Log one element this cycle |
| log_word | input | 1 | Element size: 1 = 4 bytes, 0 = 2 bytes |
| log_addr | input | 8 | Element base byte address |
| log_len | input | 8 | Region length; the bound is base+length, inclusive |
| log_idx | input | 3 | Element index within the vector |
| log_pred_en | input | 1 | Apply the predicate vector |
| log_pred | input | 16 | Predicate, one bit per log slot |
| log_inc | input | 32 | Increment value, little-endian |
| commit_req | input | 1 | Start a commit |
| commit_word | input | 1 | Commit element size: 1 = 4 bytes, 0 = 2 bytes |
| busy | output | 1 | Commit in progress |
| done | output | 1 | One-cycle end-of-commit pulse |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | 8 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte, valid one cycle after `mem_rd` |

## Verification
Logging and the start of a commit can fall in the same cycle. The bench provokes this by driving `log_valid` and `commit_req` together from idle. It judges the result by requiring that the final memory image include that element's increment. The bench also offers both requests in the middle of a running commit. It judges that case by confirming that a follow-up commit changes no memory, which shows the log never took the late entry.

// File: rtl/scat_pkg.sv
// Shared types for the scatter-accumulate engine.
// Assumes the log depth is a power of two and a multiple of four.
package scat_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_NEXT  = 3'd1,
        ST_READ  = 3'd2,
        ST_ADD   = 3'd3,
        ST_WRITE = 3'd4,
        ST_DONE  = 3'd5
    } scat_state_t;
endpackage

// File: rtl/scat_log_store.sv
// Byte-granular log: one slot per vector byte holding address, increment
// byte and valid bit. Filled by the log port; slots are cleared one at a
// time by the commit walker. Assumes log writes and clears never coincide.
module scat_log_store #(
    parameter int N_SLOTS = 16,
    parameter int ADDR_W  = 8,
    parameter int IDX_W   = 3,
    localparam int SLOT_W = $clog2(N_SLOTS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic                      wr_word,
    input  logic [ADDR_W-1:0]         wr_ea,
    input  logic [ADDR_W-1:0]         wr_len,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic                      wr_pred_en,
    input  logic [N_SLOTS-1:0]        wr_pred,
    input  logic [31:0]               wr_inc,
    input  logic                      clr_en,
    input  logic [SLOT_W-1:0]         clr_slot,
    output logic [N_SLOTS*ADDR_W-1:0] addr_flat,
    output logic [N_SLOTS*8-1:0]      data_flat,
    output logic [N_SLOTS-1:0]        mask_vec
);
    logic [ADDR_W-1:0] limit;

    // Inclusive region end, wrapping at the address width.
    always_comb limit = wr_ea + wr_len;

    for (genvar k = 0; k < N_SLOTS; k++) begin : g_slot
        localparam int OFF_W = k % 4;
        localparam int OFF_H = k % 2;
        localparam int EL_W  = k / 4;
        localparam int EL_H  = k / 2;
        logic              hit;
        logic [1:0]        off;
        logic [ADDR_W-1:0] baddr;
        logic              ok;

        // Decide whether this slot belongs to the element being logged.
        always_comb begin
            hit   = wr_word ? (int'(wr_idx) == EL_W) : (int'(wr_idx) == EL_H);
            off   = wr_word ? 2'(OFF_W) : 2'(OFF_H);
            baddr = wr_ea + ADDR_W'(off);
            ok    = (baddr <= limit) && (!wr_pred_en || wr_pred[k]);
        end

        // Slot storage: log fill or commit clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                addr_flat[k*ADDR_W +: ADDR_W] <= '0;
                data_flat[k*8 +: 8]           <= '0;
                mask_vec[k]                   <= 1'b0;
            end else if (wr_en && hit) begin
                addr_flat[k*ADDR_W +: ADDR_W] <= baddr;
                data_flat[k*8 +: 8]           <= wr_inc[{off, 3'b000} +: 8];
                mask_vec[k]                   <= ok;
            end else if (clr_en && clr_slot == SLOT_W'(k)) begin
                data_flat[k*8 +: 8]           <= '0;
                mask_vec[k]                   <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/scat_commit_fsm.sv
// Commit walker: steps through the log by element size, and for each
// element whose first slot is valid reads memory, adds the logged
// increment and writes the sum back, clearing the slots it consumes.
// Assumes a single-port byte memory with one cycle of read latency.
module scat_commit_fsm #(
    parameter int N_SLOTS = 16,
    parameter int ADDR_W  = 8,
    localparam int SLOT_W = $clog2(N_SLOTS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      commit_req,
    input  logic                      commit_word,
    input  logic [N_SLOTS*ADDR_W-1:0] addr_flat,
    input  logic [N_SLOTS*8-1:0]      data_flat,
    input  logic [N_SLOTS-1:0]        mask_vec,
    input  logic [7:0]                mem_rdata,
    output logic                      busy,
    output logic                      done,
    output logic                      mem_rd,
    output logic                      mem_wr,
    output logic [ADDR_W-1:0]         mem_addr,
    output logic [7:0]                mem_wdata,
    output logic                      clr_en,
    output logic [SLOT_W-1:0]         clr_slot
);
    import scat_pkg::*;

    scat_state_t       state;
    logic [SLOT_W:0]   ptr;
    logic [2:0]        cnt;
    logic [2:0]        cm1;
    logic [31:0]       acc;
    logic [31:0]       inc;
    logic              word_q;
    logic [2:0]        nbytes;
    logic [SLOT_W-1:0] slot;

    // Current slot, element size and assembled increment.
    always_comb begin
        nbytes = word_q ? 3'd4 : 3'd2;
        slot   = ptr[SLOT_W-1:0] + SLOT_W'(cnt);
        cm1    = cnt - 3'd1;
        inc    = '0;
        for (int j = 0; j < 4; j++) begin
            if (3'(j) < nbytes)
                inc[j*8 +: 8] = data_flat[(ptr[SLOT_W-1:0] + SLOT_W'(j))*8 +: 8];
        end
    end

    // Memory port and log clear strobes.
    always_comb begin
        busy      = (state != ST_IDLE);
        done      = (state == ST_DONE);
        mem_rd    = (state == ST_READ) && (cnt < nbytes);
        mem_wr    = (state == ST_WRITE);
        mem_addr  = addr_flat[slot*ADDR_W +: ADDR_W];
        mem_wdata = acc[{cnt[1:0], 3'b000} +: 8];
        clr_en    = (state == ST_WRITE);
        clr_slot  = slot;
    end

    // Commit sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            ptr    <= '0;
            cnt    <= '0;
            acc    <= '0;
            word_q <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (commit_req) begin
                    word_q <= commit_word;
                    ptr    <= '0;
                    state  <= ST_NEXT;
                end
                ST_NEXT: begin
                    if (ptr >= (SLOT_W+1)'(N_SLOTS)) begin
                        state <= ST_DONE;
                    end else if (mask_vec[ptr[SLOT_W-1:0]]) begin
                        cnt   <= '0;
                        acc   <= '0;
                        state <= ST_READ;
                    end else begin
                        ptr <= ptr + (SLOT_W+1)'(nbytes);
                    end
                end
                ST_READ: begin
                    if (cnt != 3'd0) acc[{cm1[1:0], 3'b000} +: 8] <= mem_rdata;
                    if (cnt == nbytes) state <= ST_ADD;
                    else               cnt   <= cnt + 3'd1;
                end
                ST_ADD: begin
                    acc   <= acc + inc;
                    cnt   <= '0;
                    state <= ST_WRITE;
                end
                ST_WRITE: begin
                    if (cnt == nbytes - 3'd1) begin
                        ptr   <= ptr + (SLOT_W+1)'(nbytes);
                        state <= ST_NEXT;
                    end else begin
                        cnt <= cnt + 3'd1;
                    end
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/scat_acc_engine.sv
// Scatter-accumulate engine top: byte log plus commit walker. Log
// requests are accepted only while no commit runs.
module scat_acc_engine #(
    parameter int N_SLOTS = 16,
    parameter int ADDR_W  = 8,
    localparam int IDX_W  = $clog2(N_SLOTS / 2),
    localparam int SLOT_W = $clog2(N_SLOTS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               log_valid,
    input  logic               log_word,
    input  logic [ADDR_W-1:0]  log_addr,
    input  logic [ADDR_W-1:0]  log_len,
    input  logic [IDX_W-1:0]   log_idx,
    input  logic               log_pred_en,
    input  logic [N_SLOTS-1:0] log_pred,
    input  logic [31:0]        log_inc,
    input  logic               commit_req,
    input  logic               commit_word,
    output logic               busy,
    output logic               done,
    output logic               mem_rd,
    output logic               mem_wr,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [7:0]         mem_wdata,
    input  logic [7:0]         mem_rdata
);
    logic [N_SLOTS*ADDR_W-1:0] addr_flat;
    logic [N_SLOTS*8-1:0]      data_flat;
    logic [N_SLOTS-1:0]        mask_vec;
    logic                      clr_en;
    logic [SLOT_W-1:0]         clr_slot;
    logic                      log_go;

    // Log acceptance is refused during a commit.
    always_comb log_go = log_valid && !busy;

    scat_log_store #(.N_SLOTS(N_SLOTS), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_log (
        .clk(clk), .rst_n(rst_n),
        .wr_en(log_go), .wr_word(log_word), .wr_ea(log_addr), .wr_len(log_len),
        .wr_idx(log_idx), .wr_pred_en(log_pred_en), .wr_pred(log_pred),
        .wr_inc(log_inc), .clr_en(clr_en), .clr_slot(clr_slot),
        .addr_flat(addr_flat), .data_flat(data_flat), .mask_vec(mask_vec)
    );

    scat_commit_fsm #(.N_SLOTS(N_SLOTS), .ADDR_W(ADDR_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .commit_req(commit_req), .commit_word(commit_word),
        .addr_flat(addr_flat), .data_flat(data_flat), .mask_vec(mask_vec),
        .mem_rdata(mem_rdata), .busy(busy), .done(done),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .clr_en(clr_en), .clr_slot(clr_slot)
    );
endmodule

// File: rtl/scat_acc_engine_chk.sv
// Port-level protocol checks for the scatter-accumulate engine.
module scat_acc_engine_chk (
    input logic clk,
    input logic rst_n,
    input logic commit_req,
    input logic busy,
    input logic done,
    input logic mem_rd,
    input logic mem_wr
);
    // R11
    port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));
    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> busy);
    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8
    done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
    // R8
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && commit_req) |=> busy);
    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
    // R6
    read_before_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wr) |-> !mem_rd);
endmodule

bind scat_acc_engine scat_acc_engine_chk u_chk (
    .clk(clk), .rst_n(rst_n), .commit_req(commit_req), .busy(busy),
    .done(done), .mem_rd(mem_rd), .mem_wr(mem_wr)
);

// File: tb/scat_acc_engine_tb.sv
module scat_acc_engine_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        log_valid = 1'b0, log_word = 1'b0, log_pred_en = 1'b0;
    logic [7:0]  log_addr = '0, log_len = '0;
    logic [2:0]  log_idx = '0;
    logic [15:0] log_pred = '0;
    logic [31:0] log_inc = '0;
    logic        commit_req = 1'b0, commit_word = 1'b0;
    logic        busy, done, mem_rd, mem_wr;
    logic [7:0]  mem_addr, mem_wdata, mem_rdata;

    int n_chk = 0, n_fail = 0, port_viol = 0;
    logic [7:0] mem [256];
    logic [7:0] exp_mem [256];
    logic [7:0] ref_addr [16];
    logic [7:0] ref_data [16];
    logic       ref_mask [16];

    always #4 clk = ~clk;

    scat_acc_engine u_dut (.*);

    // Single-port byte memory with one cycle of read latency.
    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr];
    end

    // R11 monitor sampled away from the edge.
    always @(negedge clk) if (rst_n && ((mem_rd && mem_wr) || ((mem_rd || mem_wr) && !busy)))
        port_viol++;

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run hung act=timeout exp=finish");
        summary();
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    task automatic ref_log(input bit w, input logic [7:0] ea, input logic [7:0] len,
                           input int idx, input bit pe, input logic [15:0] pr,
                           input logic [31:0] inc);
        int s = w ? 4 : 2;
        for (int k = 0; k < 16; k++) begin
            if (k / s == idx) begin
                int off = k % s;
                logic [7:0] a = ea + 8'(off);
                logic [7:0] lim = ea + len;
                ref_addr[k] = a;
                ref_data[k] = inc[off*8 +: 8];
                ref_mask[k] = (a <= lim) && (!pe || pr[k]);
            end
        end
    endtask

    task automatic ref_commit(input bit w);
        int s = w ? 4 : 2;
        for (int p = 0; p < 16; p += s) begin
            if (ref_mask[p]) begin
                logic [31:0] dst = 0, iv = 0;
                for (int j = 0; j < s; j++) begin
                    dst[j*8 +: 8] = exp_mem[ref_addr[p+j]];
                    iv[j*8 +: 8]  = ref_data[p+j];
                    ref_mask[p+j] = 1'b0;
                    ref_data[p+j] = 8'h00;
                end
                dst = dst + iv;
                for (int j = 0; j < s; j++) exp_mem[ref_addr[p+j]] = dst[j*8 +: 8];
            end
        end
    endtask

    task automatic do_log(input bit w, input logic [7:0] ea, input logic [7:0] len,
                          input int idx, input bit pe, input logic [15:0] pr,
                          input logic [31:0] inc);
        @(negedge clk);
        log_valid = 1; log_word = w; log_addr = ea; log_len = len;
        log_idx = 3'(idx); log_pred_en = pe; log_pred = pr; log_inc = inc;
        @(negedge clk);
        log_valid = 0;
        ref_log(w, ea, len, idx, pe, pr, inc);
    endtask

    task automatic wait_done(input string req);
        bit seen = 0;
        for (int c = 0; c < 2000; c++) begin
            if (done) begin seen = 1; break; end
            @(negedge clk);
        end
        chk(seen, req, "done pulse seen", seen, 1);
        @(negedge clk);
        chk(!done && !busy, "R8", "done one cycle then idle", {done, busy}, 0);
    endtask

    task automatic cmp_mem(input string req);
        int bad = 0, first = -1;
        for (int a = 0; a < 256; a++) if (mem[a] !== exp_mem[a]) begin
            bad++; if (first < 0) first = a;
        end
        if (first < 0) chk(1, req, "memory image", 0, 0);
        else chk(0, req, $sformatf("memory byte %0h", first), mem[first], exp_mem[first]);
    endtask

    // Commit (optionally with a same-cycle log), optional late requests while busy.
    task automatic do_commit(input bit w, input bit poke_busy);
        @(negedge clk);
        commit_req = 1; commit_word = w;
        @(negedge clk);
        commit_req = 0;
        chk(busy, "R8", "busy after start", busy, 1);
        if (poke_busy) begin
            log_valid = 1; log_word = 1; log_addr = 8'h40; log_len = 8'h3;
            log_idx = 0; log_pred_en = 0; log_inc = 32'h11111111; commit_req = 1;
            @(negedge clk);
            log_valid = 0; commit_req = 0;
        end
        wait_done("R8");
        ref_commit(w);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int a = 0; a < 256; a++) begin
            mem[a] = 8'($urandom); exp_mem[a] = mem[a];
        end
        for (int k = 0; k < 16; k++) begin
            ref_addr[k] = 0; ref_data[k] = 0; ref_mask[k] = 0;
        end
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!busy && !done && !mem_rd && !mem_wr, "R1", "reset outputs",
            {busy, done, mem_rd, mem_wr}, 0);
        rst_n = 1;

        // R2 R6: word element slots 4..7 with carry across bytes
        exp_mem[8'h10] = 8'hFF; mem[8'h10] = 8'hFF;
        do_log(1, 8'h10, 8'h3, 1, 0, 16'h0, 32'h01020301);
        do_commit(1, 0);
        cmp_mem("R2");
        chk(mem[8'h10] == 8'h00 && mem[8'h11] == exp_mem[8'h11], "R6",
            "carry byte", mem[8'h10], 0);

        // R7: repeat commit with no new log changes nothing
        do_commit(1, 0);
        cmp_mem("R7");

        // R3: wrap of inclusive bound invalidates first byte; len 0 still valid
        do_log(1, 8'hFE, 8'h3, 0, 0, 16'h0, 32'h05050505);
        do_log(1, 8'h20, 8'h0, 2, 0, 16'h0, 32'h00000707);
        do_commit(1, 0);
        cmp_mem("R3");
        do_commit(0, 0);
        cmp_mem("R3");

        // R4: predicate clears first byte of halfword 3, keeps halfword 5
        do_log(0, 8'h30, 8'h1, 3, 1, 16'b0000_1100_1000_0000, 32'h0000AA55);
        do_log(0, 8'h34, 8'h1, 5, 1, 16'b0000_0100_0000_0000, 32'h00000102);
        do_commit(0, 0);
        cmp_mem("R4");
        do_commit(0, 0);
        cmp_mem("R5");

        // R9: late log and commit during busy are dropped
        do_log(1, 8'h50, 8'h3, 2, 0, 16'h0, 32'h00000009);
        do_commit(1, 1);
        cmp_mem("R9");
        do_commit(1, 0);
        cmp_mem("R9");

        // R10: log and commit in the same idle cycle
        @(negedge clk);
        log_valid = 1; log_word = 1; log_addr = 8'h60; log_len = 8'h3;
        log_idx = 3; log_pred_en = 0; log_inc = 32'h0000_0033;
        commit_req = 1; commit_word = 1;
        ref_log(1, 8'h60, 8'h3, 3, 0, 16'h0, 32'h0000_0033);
        @(negedge clk);
        log_valid = 0; commit_req = 0;
        wait_done("R10");
        ref_commit(1);
        cmp_mem("R10");

        // Random rounds: overlapping addresses, wraps, predicates, size mixes (R5 R6)
        for (int r = 0; r < 40; r++) begin
            int n = 1 + int'($urandom % 5);
            bit w = 1'($urandom);
            for (int e = 0; e < n; e++) begin
                do_log(w, 8'($urandom % 24) + ((($urandom % 8) == 0) ? 8'hF0 : 8'h80),
                       8'($urandom % 6), int'($urandom % (w ? 4 : 8)),
                       1'($urandom), 16'($urandom), $urandom);
            end
            do_commit((($urandom % 4) == 0) ? !w : w, 1'(($urandom % 6) == 0));
            cmp_mem("R6");
        end

        chk(port_viol == 0, "R11", "port exclusivity violations", port_viol, 0);
        summary();
    end
endmodule